// File: doc/BRIEF.md
# Multichannel Successive-Approximation Conversion Sequencer

This block drives a successive-approximation converter that is shared by eight multiplexed analog inputs. The analog multiplexer, the trial DAC, the comparator and the sample-and-hold all sit outside the block. The block selects an input, holds a fixed settle-and-sample interval, and then runs a binary search over the DAC code, most significant bit first. It reads one comparator bit at the end of each bit slot. Each finished conversion is stored in a result register for the channel it belongs to.

Software drives the block through a single register port. A write to the control word sets the input channel, the conversion mode, the sweep set, the resolution, the sample-and-hold timing, the ADC clock divide, the interrupt level and a start flag. In the modes that end by themselves, the hardware clears the start flag. The interrupt output pulses only when a one-shot conversion finishes. Results are read back from eight addresses, right-justified and zero-extended to 16 bits.

Top module: `sar_seq_top`

## Requirements
- R1: The search starts from an all-zero code. For each bit position, MSB first, it drives the DAC with the current code plus that bit set. It keeps the bit when `cmp_hi` is 1, meaning the input is at or above the DAC level. The stored result is therefore the largest code not above the input. During the sample interval the DAC code is 0.
- R2: Writing the control word (address 8) with bit 15 = 1 starts a run. The hardware clears bit 15 when a one-shot conversion or the final conversion of a single sweep completes. In the repeat modes bit 15 stays 1 until software writes it to 0. Writing 0 also stops a conversion that is in progress, and nothing is stored for it.
- R3: The mode field sits in control bits 5:3 and the set field in bits 7:6. Mode 0 is one-shot and mode 1 is repeat of the channel given in bits 2:0. Mode 2 sweeps once and mode 3 sweeps repeatedly, both over channels 0..(2*set+1). Mode 4 sweeps repeatedly over channels 0..set. A sweep always begins at channel 0. Codes 5 to 7 behave as mode 0.
- R4: `irq` is high for exactly one clock after a one-shot conversion completes, and only when the level field (bits 14:13) is nonzero. No other mode raises it.
- R5: When bit 8 is 1 the search covers only the upper 8 DAC bits, and the 8-bit result sits in result bits 7:0. When bit 8 is 0 the result is 10 bits. Bits 15:10 of every result register read as 0.
- R6: A conversion takes T ADC-clock ticks. T is 28 (8-bit) or 33 (10-bit) when bit 9 (sample-and-hold) is 1, and 49 or 59 when bit 9 is 0. The settle interval is part of T. The first conversion launches one clock after the start write, and each following conversion launches one clock after the previous one completes.
- R7: Bits 12:10 select the ADC clock divide: codes 0 to 4 give 1, 2, 3, 4 and 6, and codes 5 to 7 give 12. One conversion therefore lasts T times the divide in input clocks.
- R8: A control write made during a conversion affects channel, mode, timing and divide only from the next launch.
- R9: Address 8 reads back the control word with the live start flag in bit 15. Addresses 0 to 7 read the result registers, which are 0 after reset. All other addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for read and write |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for `addr` |
| amux_sel | output | 3 | Analog multiplexer channel |
| track | output | 1 | Sample-and-hold tracking during the sample interval |
| dac_code | output | 10 | Trial code to the external DAC |
| cmp_hi | input | 1 | Comparator: input at or above the DAC level |
| irq | output | 1 | One-shot completion pulse |

## Verification
The bench builds the block with its default parameters: eight channels, 10-bit full resolution with an 8-bit reduced mode, the four stated tick totals, and a divide of up to 12. With these values every divide code, both resolutions and both timing variants fall within a few hundred clocks each. The external comparator is modelled against a per-channel input code, so results at 0, full scale and odd bit patterns can be predicted exactly. Every sweep set can be covered, and a reconfiguration or stop can be timed to land in the middle of a conversion.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    localparam int CH_W = 3;

    localparam logic [2:0] MODE_ONCE   = 3'd0;
    localparam logic [2:0] MODE_HOLD   = 3'd1;
    localparam logic [2:0] MODE_SWEEP  = 3'd2;
    localparam logic [2:0] MODE_LOOP_A = 3'd3;
    localparam logic [2:0] MODE_LOOP_B = 3'd4;

    // control word bits 14:0, start flag kept apart
    typedef struct packed {
        logic [1:0]      irq_lvl;
        logic [2:0]      div_code;
        logic            sh_en;
        logic            lo_res;
        logic [1:0]      set;
        logic [2:0]      mode;
        logic [CH_W-1:0] chan;
    } ctrl_t;

    function automatic logic [3:0] div_ratio(input logic [2:0] code);
        case (code)
            3'd0:    return 4'd1;
            3'd1:    return 4'd2;
            3'd2:    return 4'd3;
            3'd3:    return 4'd4;
            3'd4:    return 4'd6;
            default: return 4'd12;
        endcase
    endfunction

    function automatic logic is_sweep(input logic [2:0] m);
        return (m == MODE_SWEEP) || (m == MODE_LOOP_A) || (m == MODE_LOOP_B);
    endfunction

    function automatic logic is_once(input logic [2:0] m);
        return !(is_sweep(m) || (m == MODE_HOLD));
    endfunction

    function automatic logic [CH_W-1:0] last_chan(input logic [2:0] m, input logic [1:0] s);
        if (m == MODE_LOOP_B) return {1'b0, s};
        return {s, 1'b1};
    endfunction

endpackage

// File: rtl/sar_clk_en.sv
module sar_clk_en #(
    parameter int MAX_DIV = 12,
    localparam int CNT_W  = $clog2(MAX_DIV + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] ratio,
    output logic             tick
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = run && (st_q.cnt == ratio - 1'b1);
        if (!run || tick) st_d.cnt = '0;
        else              st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7: with a divide above one, ticks never come back to back
    p_tick_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ratio != 1) |=> !tick);

endmodule

// File: rtl/sar_engine.sv
module sar_engine #(
    parameter int RES_BITS = 10,
    parameter int LO_BITS  = 8,
    parameter int T_SH_LO  = 28,
    parameter int T_SH_HI  = 33,
    parameter int T_NS_LO  = 49,
    parameter int T_NS_HI  = 59,
    parameter int P_SH     = 2,
    parameter int P_NS     = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                launch,
    input  logic                abort,
    input  logic                tick,
    input  logic                lo_res,
    input  logic                sh_en,
    input  logic                cmp_hi,
    output logic                active,
    output logic                done,
    output logic                track,
    output logic [RES_BITS-1:0] dac_code,
    output logic [RES_BITS-1:0] result
);
    localparam int CNT_W = $clog2(T_NS_HI + 1);
    localparam int PC_W  = $clog2(((P_SH > P_NS) ? P_SH : P_NS) + 1);
    localparam logic [CNT_W-1:0] S_SH_LO = CNT_W'(T_SH_LO - LO_BITS * P_SH);
    localparam logic [CNT_W-1:0] S_SH_HI = CNT_W'(T_SH_HI - RES_BITS * P_SH);
    localparam logic [CNT_W-1:0] S_NS_LO = CNT_W'(T_NS_LO - LO_BITS * P_NS);
    localparam logic [CNT_W-1:0] S_NS_HI = CNT_W'(T_NS_HI - RES_BITS * P_NS);
    localparam logic [RES_BITS-1:0] MSB_MASK = {1'b1, {(RES_BITS-1){1'b0}}};
    localparam logic [RES_BITS-1:0] END_LO   = RES_BITS'(1) << (RES_BITS - LO_BITS);
    localparam logic [RES_BITS-1:0] END_HI   = RES_BITS'(1);

    typedef struct packed {
        logic                active;
        logic                in_bits;
        logic [RES_BITS-1:0] code;
        logic [RES_BITS-1:0] mask;
        logic [CNT_W-1:0]    tcnt;
        logic [PC_W-1:0]     pcnt;
    } st_t;

    st_t st_d, st_q;
    logic [CNT_W-1:0]    samp_len;
    logic [PC_W-1:0]     per_bit;
    logic [RES_BITS-1:0] end_mask;

    always_comb begin
        if (sh_en) samp_len = lo_res ? S_SH_LO : S_SH_HI;
        else       samp_len = lo_res ? S_NS_LO : S_NS_HI;
        per_bit  = sh_en ? PC_W'(P_SH) : PC_W'(P_NS);
        end_mask = lo_res ? END_LO : END_HI;
    end

    always_comb begin
        st_d = st_q;
        done = 1'b0;
        if (abort) begin
            st_d.active  = 1'b0;
            st_d.in_bits = 1'b0;
        end else if (launch) begin
            st_d.active  = 1'b1;
            st_d.in_bits = 1'b0;
            st_d.code    = '0;
            st_d.mask    = MSB_MASK;
            st_d.tcnt    = '0;
            st_d.pcnt    = '0;
        end else if (st_q.active && tick) begin
            if (!st_q.in_bits) begin
                if (st_q.tcnt == samp_len - 1'b1) begin
                    st_d.in_bits = 1'b1;
                    st_d.tcnt    = '0;
                end else begin
                    st_d.tcnt = st_q.tcnt + 1'b1;
                end
            end else if (st_q.pcnt == per_bit - 1'b1) begin
                st_d.pcnt = '0;
                if (cmp_hi) st_d.code = st_q.code | st_q.mask;
                st_d.mask = st_q.mask >> 1;
                if (st_q.mask == end_mask) begin
                    st_d.active  = 1'b0;
                    st_d.in_bits = 1'b0;
                    done         = 1'b1;
                end
            end else begin
                st_d.pcnt = st_q.pcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active   = st_q.active;
    assign track    = st_q.active && !st_q.in_bits && sh_en;
    assign dac_code = (st_q.active && st_q.in_bits) ? (st_q.code | st_q.mask) : '0;
    assign result   = lo_res ? (st_d.code >> (RES_BITS - LO_BITS)) : st_d.code;

    // R1: exactly one trial bit is under test throughout a conversion
    p_one_trial_r1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.active |-> $onehot(st_q.mask));

    // R1: the DAC rests at zero while the input is being sampled
    p_sample_dac_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        track |-> (dac_code == '0));

endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
    import sar_seq_pkg::*;
#(
    parameter int NUM_CH   = 8,
    parameter int RES_BITS = 10,
    parameter int LO_BITS  = 8,
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = 4,
    parameter int T_SH_LO  = 28,
    parameter int T_SH_HI  = 33,
    parameter int T_NS_LO  = 49,
    parameter int T_NS_HI  = 59,
    parameter int P_SH     = 2,
    parameter int P_NS     = 4,
    parameter int MAX_DIV  = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [DATA_W-1:0]   rd_data,
    output logic [CH_W-1:0]     amux_sel,
    output logic                track,
    output logic [RES_BITS-1:0] dac_code,
    input  logic                cmp_hi,
    output logic                irq
);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_CH);
    localparam int DIV_W = $clog2(MAX_DIV + 1);

    typedef struct packed {
        logic                            start;
        logic                            first;
        ctrl_t                           ctrl;
        ctrl_t                           cfg;
        logic [CH_W-1:0]                 ch;
        logic                            irq;
        logic [NUM_CH-1:0][RES_BITS-1:0] res;
    } st_t;

    st_t st_d, st_q;

    logic                wctrl, abort, launch, term;
    logic                eng_active, eng_done, tick;
    logic [RES_BITS-1:0] eng_res;
    logic [CH_W-1:0]     ctrl_last;

    assign wctrl     = wr_en && (addr == CTRL_ADDR);
    assign abort     = wctrl && !wr_data[DATA_W-1];
    assign launch    = st_q.start && !eng_active && !abort;
    assign ctrl_last = last_chan(st_q.ctrl.mode, st_q.ctrl.set);
    assign term      = is_once(st_q.cfg.mode) ||
                       ((st_q.cfg.mode == MODE_SWEEP) &&
                        (st_q.ch == last_chan(st_q.cfg.mode, st_q.cfg.set)));

    sar_clk_en #(.MAX_DIV(MAX_DIV)) u_clk_en (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (eng_active),
        .ratio (DIV_W'(div_ratio(st_q.cfg.div_code))),
        .tick  (tick)
    );

    sar_engine #(
        .RES_BITS(RES_BITS), .LO_BITS(LO_BITS),
        .T_SH_LO(T_SH_LO), .T_SH_HI(T_SH_HI), .T_NS_LO(T_NS_LO), .T_NS_HI(T_NS_HI),
        .P_SH(P_SH), .P_NS(P_NS)
    ) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (launch),
        .abort    (abort),
        .tick     (tick),
        .lo_res   (st_q.cfg.lo_res),
        .sh_en    (st_q.cfg.sh_en),
        .cmp_hi   (cmp_hi),
        .active   (eng_active),
        .done     (eng_done),
        .track    (track),
        .dac_code (dac_code),
        .result   (eng_res)
    );

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (launch) begin
            st_d.cfg   = st_q.ctrl;
            st_d.first = 1'b0;
            if (is_sweep(st_q.ctrl.mode)) begin
                if (st_q.first || (st_q.ch >= ctrl_last)) st_d.ch = '0;
                else                                      st_d.ch = st_q.ch + 1'b1;
            end else begin
                st_d.ch = st_q.ctrl.chan;
            end
        end
        if (eng_done && !abort) begin
            st_d.res[st_q.ch] = eng_res;
            st_d.irq = is_once(st_q.cfg.mode) && (st_q.cfg.irq_lvl != 2'd0);
        end
        if (wctrl) begin
            if (wr_data[DATA_W-1] && !st_q.start) st_d.first = 1'b1;
            st_d.start = wr_data[DATA_W-1];
            st_d.ctrl  = ctrl_t'(wr_data[DATA_W-2:0]);
        end else if (eng_done && term) begin
            st_d.start = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data = '0;
        if (addr < CTRL_ADDR)       rd_data = DATA_W'(st_q.res[addr[CH_W-1:0]]);
        else if (addr == CTRL_ADDR) rd_data = {st_q.start, st_q.ctrl};
    end

    assign amux_sel = st_q.ch;
    assign irq      = st_q.irq;

    // R4: the completion pulse only follows a one-shot conversion
    p_irq_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> is_once(st_q.cfg.mode));

    // R2: a repeat run keeps its start flag while software stays away
    p_repeat_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.start && !wctrl && eng_active && !is_once(st_q.cfg.mode) &&
         st_q.cfg.mode != MODE_SWEEP) |=> st_q.start);

    // R3: a sweep never leaves its channel set
    p_sweep_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_active && is_sweep(st_q.cfg.mode)) |->
        (st_q.ch <= last_chan(st_q.cfg.mode, st_q.cfg.set)));

    // R3: single-channel modes convert the channel they were launched with
    p_fixed_chan_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_active && !is_sweep(st_q.cfg.mode)) |-> (st_q.ch == st_q.cfg.chan));

    // R5: an 8-bit result never reaches the upper result bits
    p_lo_narrow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && st_q.cfg.lo_res) |-> (eng_res[RES_BITS-1:LO_BITS] == '0));

endmodule

// File: tb/tb_sar_seq_top.sv
module tb_sar_seq_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = 4'd8;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic [2:0]  amux_sel;
    logic        track;
    logic [9:0]  dac_code;
    logic        cmp_hi;
    logic        irq;
    logic [9:0]  vin [8];

    int checks = 0, errors = 0;
    int irq_cnt = 0, ch_max = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // external comparator: input at or above the DAC level
    assign cmp_hi = (vin[amux_sel] >= dac_code);

    sar_seq_top dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .amux_sel(amux_sel), .track(track), .dac_code(dac_code),
        .cmp_hi(cmp_hi), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] mk(bit st, int lvl, int dv, bit sh, bit lo, int st_set, int md, int ch);
        return {st, 2'(lvl), 3'(dv), sh, lo, 2'(st_set), 3'(md), 3'(ch)};
    endfunction

    function automatic int t_of(bit lo, bit sh);
        if (sh) return lo ? 28 : 33;
        return lo ? 49 : 59;
    endfunction

    function automatic int d_of(int c);
        case (c)
            0: return 1;  1: return 2;  2: return 3;
            3: return 4;  4: return 6;  default: return 12;
        endcase
    endfunction

    function automatic int last_of(int md, int s);
        return (md == 4) ? s : 2*s + 1;
    endfunction

    // behavioural reference model
    bit        m_start, m_first, m_active, m_irq;
    int        m_rem, m_ch;
    logic [14:0] m_ctrl, m_cfg;
    int        m_res [8];
    bit        wc, ab, dn, once, term;
    int        md;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_start = 0; m_first = 0; m_active = 0; m_irq = 0;
            m_rem = 0; m_ch = 0; m_ctrl = '0; m_cfg = '0;
            for (int i = 0; i < 8; i++) m_res[i] = 0;
        end else begin
            wc = wr_en && (addr == 4'd8);
            ab = wc && !wr_data[15];
            dn = 0;
            if (m_active) begin
                if (ab) m_active = 0;
                else if (m_rem == 1) begin
                    dn = 1; m_active = 0;
                    m_res[m_ch] = m_cfg[8] ? int'(vin[m_ch]) / 4 : int'(vin[m_ch]);
                end else m_rem--;
            end else if (m_start && !ab) begin
                m_cfg = m_ctrl;
                md = int'(m_cfg[5:3]);
                if (md >= 2 && md <= 4)
                    m_ch = (m_first || m_ch >= last_of(md, int'(m_cfg[7:6]))) ? 0 : m_ch + 1;
                else
                    m_ch = int'(m_cfg[2:0]);
                m_first = 0;
                m_rem = t_of(m_cfg[8], m_cfg[9]) * d_of(int'(m_cfg[12:10]));
                m_active = 1;
            end
            md   = int'(m_cfg[5:3]);
            once = !(md >= 1 && md <= 4);
            m_irq = dn && once && (m_cfg[14:13] != 2'd0);
            term = dn && (once || (md == 2 && m_ch == last_of(md, int'(m_cfg[7:6]))));
            if (wc) begin
                if (wr_data[15] && !m_start) m_first = 1;
                m_start = wr_data[15];
                m_ctrl = wr_data[14:0];
            end else if (term) m_start = 0;
        end
    end

    // compare on every clock
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            chk(irq == m_irq, "R4 irq", int'(irq), int'(m_irq));
            if (addr == 4'd8)
                chk(rd_data == {m_start, m_ctrl}, "R2/R9 control readback", int'(rd_data), int'({m_start, m_ctrl}));
            else if (addr < 4'd8)
                chk(int'(rd_data) == m_res[addr], "R1/R5 result", int'(rd_data), m_res[addr]);
            else
                chk(rd_data == 16'd0, "R9 unused address", int'(rd_data), 0);
            if (m_active) begin
                chk(int'(amux_sel) == m_ch, "R3 channel", int'(amux_sel), m_ch);
                if (int'(amux_sel) > ch_max) ch_max = int'(amux_sel);
            end
        end
    end

    always @(posedge clk) if (rst_n && irq) irq_cnt++;

    task automatic wr(input logic [15:0] d);
        @(negedge clk); wr_en = 1'b1; addr = 4'd8; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        @(negedge clk); addr = 4'(a);
        @(posedge clk); #2; v = int'(rd_data);
        @(negedge clk); addr = 4'd8;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (n < 5000) begin
            @(posedge clk); #2; n++;
            if (!rd_data[15]) break;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n, v, i0;
        vin[0] = 10'h155; vin[1] = 10'h001; vin[2] = 10'h2C3; vin[3] = 10'h2A5;
        vin[4] = 10'h1F0; vin[5] = 10'h3FF; vin[6] = 10'h0AA; vin[7] = 10'h203;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // reset state
        rd(8, v); chk(v == 0, "R9 reset control", v, 0);
        rd(0, v); chk(v == 0, "R9 reset result", v, 0);
        chk(irq == 1'b0, "R4 reset irq", int'(irq), 0);

        // one-shot, 10-bit, S/H, divide 1, interrupt level 1
        i0 = irq_cnt;
        wr(mk(1, 1, 0, 1, 0, 0, 0, 3)); wait_idle(n);
        chk(n == 1 + 33, "R6 one-shot 10-bit S/H duration", n, 34);
        rd(3, v); chk(v == 'h2A5, "R1 search result", v, 'h2A5);
        chk(irq_cnt - i0 == 1, "R4 one-shot pulse", irq_cnt - i0, 1);

        // one-shot, 8-bit, S/H, divide 2, level 0
        i0 = irq_cnt;
        wr(mk(1, 0, 1, 1, 1, 0, 0, 5)); wait_idle(n);
        chk(n == 1 + 28*2, "R7 divide 2 duration", n, 57);
        rd(5, v); chk(v == 'hFF, "R5 8-bit full scale", v, 'hFF);
        chk(irq_cnt - i0 == 0, "R4 level zero silent", irq_cnt - i0, 0);

        // one-shot without S/H, 10-bit, divide 3
        wr(mk(1, 2, 2, 0, 0, 0, 0, 0)); wait_idle(n);
        chk(n == 1 + 59*3, "R6 no S/H 10-bit duration", n, 178);
        rd(0, v); chk(v == 'h155, "R1 alternating bits", v, 'h155);

        // one-shot without S/H, 8-bit, divide code 5 (12)
        wr(mk(1, 1, 5, 0, 1, 0, 0, 7)); wait_idle(n);
        chk(n == 1 + 49*12, "R7 divide 12 duration", n, 589);
        rd(7, v); chk(v == 'h80, "R5 8-bit result", v, 'h80);

        // divides 4 and 6, input codes at the ends of the range
        vin[1] = 10'h000;
        wr(mk(1, 1, 3, 1, 0, 0, 0, 1)); wait_idle(n);
        chk(n == 1 + 33*4, "R7 divide 4 duration", n, 133);
        rd(1, v); chk(v == 0, "R1 zero input", v, 0);
        vin[1] = 10'h3FF;
        wr(mk(1, 1, 4, 1, 0, 0, 0, 1)); wait_idle(n);
        chk(n == 1 + 33*6, "R7 divide 6 duration", n, 199);
        rd(1, v); chk(v == 'h3FF, "R5 10-bit full scale, upper bits zero", v, 'h3FF);

        // abort mid conversion: nothing stored for channel 4
        wr(mk(1, 1, 5, 1, 0, 0, 0, 4));
        repeat (50) @(posedge clk);
        wr(mk(0, 1, 5, 1, 0, 0, 0, 4));
        repeat (400) @(posedge clk);
        rd(4, v); chk(v == 0, "R2 aborted conversion not stored", v, 0);
        rd(8, v); chk(v[15] == 0, "R2 stop clears start", v >> 15, 0);

        // repeat single channel, then a mid-run channel change
        i0 = irq_cnt;
        wr(mk(1, 1, 0, 1, 0, 0, 1, 2));
        repeat (150) @(posedge clk);
        wr(mk(1, 1, 0, 1, 0, 0, 1, 6));
        repeat (150) @(posedge clk); #2;
        chk(rd_data[15] == 1'b1, "R2 repeat keeps start", int'(rd_data[15]), 1);
        chk(irq_cnt - i0 == 0, "R4 repeat silent", irq_cnt - i0, 0);
        wr(mk(0, 1, 0, 1, 0, 0, 1, 6));
        repeat (40) @(posedge clk);
        rd(2, v); chk(v == 'h2C3, "R8 first channel result", v, 'h2C3);
        rd(6, v); chk(v == 'h0AA, "R8 new channel from next launch", v, 'h0AA);

        // single sweep over channels 0..5, 8-bit, divide 1
        vin[0] = 10'h3A7; ch_max = 0;
        wr(mk(1, 1, 0, 1, 1, 2, 2, 0)); wait_idle(n);
        chk(n == 6 * 29, "R3 single sweep ends after six conversions", n, 174);
        chk(ch_max == 5, "R3 sweep set 0..5", ch_max, 5);
        rd(0, v); chk(v == 'hE9, "R3 sweep stored channel 0", v, 'hE9);
        for (int k = 0; k < 8; k++) rd(k, v);

        // repeat sweep mode 3 over 0..1
        ch_max = 0;
        wr(mk(1, 1, 0, 1, 1, 0, 3, 0));
        repeat (300) @(posedge clk); #2;
        chk(rd_data[15] == 1'b1, "R2 repeat sweep keeps start", int'(rd_data[15]), 1);
        wr(mk(0, 1, 0, 1, 1, 0, 3, 0));
        chk(ch_max == 1, "R3 repeat sweep set 0..1", ch_max, 1);

        // repeat sweep mode 4 over 0..2, then set 0 (channel 0 only)
        ch_max = 0;
        wr(mk(1, 0, 0, 1, 1, 2, 4, 0));
        repeat (400) @(posedge clk);
        wr(mk(0, 0, 0, 1, 1, 2, 4, 0));
        chk(ch_max == 2, "R3 mode 4 set 0..2", ch_max, 2);
        ch_max = 0;
        wr(mk(1, 0, 0, 1, 1, 0, 4, 0));
        repeat (200) @(posedge clk);
        wr(mk(0, 0, 0, 1, 1, 0, 4, 0));
        chk(ch_max == 0, "R3 mode 4 set 0 only", ch_max, 0);

        rd(9, v); chk(v == 0, "R9 unused address reads zero", v, 0);
        repeat (5) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule